// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

After reset, this block drives the command pins of an SDRAM device through the start-up sequence that the device requires. The clock-enable pin stays high throughout. First there is an idle wait of a programmable number of clocks, during which only no-operation commands are sent. Next comes one precharge that closes every bank. Eight auto-refresh commands follow, one on each clock. Then a load-mode command writes a fixed mode word, and the chip select is released for a short recovery gap. After that, a ready flag rises and stays high until the next reset.

The block has no data path, so it has no stream handshake. Every pin is a plain control or status signal. A memory controller holds off its own command issue until `init_done` is high. From then on it owns the command bus, and this block keeps driving no-operation commands. If reset is asserted at any point, the whole sequence starts again from the beginning of the wait.

Top module: `sdram_init_seq`

## Requirements
- R1: For cycles 0 to WAIT_CYCLES-1 after reset release, the command is NOP. NOP is cs_n=0, ras_n=1, cas_n=1 and we_n=1, with address and bank at 0. Cycle k is the interval after the k-th rising edge seen with reset released.
- R2: At cycle WAIT_CYCLES the block issues a precharge to all banks. This is cs_n=0, ras_n=0, cas_n=1 and we_n=0, with only address bit 10 set and bank 0.
- R3: At cycles WAIT_CYCLES+1 to WAIT_CYCLES+8, the block issues exactly eight back-to-back auto-refresh commands. Each is cs_n=0, ras_n=0, cas_n=0 and we_n=1, with address and bank 0.
- R4: At cycle WAIT_CYCLES+9 the block issues a load-mode command. All four control lines are low, the address equals MODE_WORD (default 0x021) and the bank is 0.
- R5: At cycles WAIT_CYCLES+10 and WAIT_CYCLES+11 the device is deselected. All four control lines are high and the address is 0.
- R6: `init_done` is low before cycle WAIT_CYCLES+12 and high from that cycle on until reset. While it is high, the command is NOP.
- R7: `sd_cke` is high in every cycle, including while reset is asserted.
- R8: Asserting reset, asynchronously and at any point, returns the block to cycle 0 of the wait with `init_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | Clock enable, always high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The bench builds two instances, one with WAIT_CYCLES=20 and one with WAIT_CYCLES=1. The second makes the precharge follow the first clock directly, which tests the wait counter's terminal compare at its smallest value. Both instances see the same reset pattern. Reset is applied at start-up, again in the middle of the refresh burst, and again after `init_done` has risen. This tests restart from a partly completed sequence and the clearing of the ready flag. Every clock, each instance's whole command bus is compared with the cycle number the bench derives from the requirements.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    PH_WAIT      = 3'd0,
    PH_PRECHARGE = 3'd1,
    PH_REFRESH   = 3'd2,
    PH_MODESET   = 3'd3,
    PH_GAP       = 3'd4,
    PH_READY     = 3'd5
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdcmd_t;

  localparam sdcmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdcmd_t CMD_PALL  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdcmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdcmd_t CMD_LMODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam sdcmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (run)   count_q <= count_q + 1'b1;
  end

  assign hit = (count_q == limit);

endmodule

// File: rtl/sdinit_fsm.sv
module sdinit_fsm
  import sdinit_pkg::*;
#(
  parameter int WAIT_CYCLES     = 10000,
  parameter int REFRESH_COUNT   = 8,
  parameter int RECOVERY_CYCLES = 2,
  parameter int CNT_W           = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output phase_e           phase,
  output logic             run,
  output logic             clear,
  output logic [CNT_W-1:0] limit
);

  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REF_LAST  = CNT_W'(REFRESH_COUNT - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(RECOVERY_CYCLES - 1);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_WAIT:      if (hit) phase_d = PH_PRECHARGE;
      PH_PRECHARGE: phase_d = PH_REFRESH;
      PH_REFRESH:   if (hit) phase_d = PH_MODESET;
      PH_MODESET:   phase_d = PH_GAP;
      PH_GAP:       if (hit) phase_d = PH_READY;
      PH_READY:     phase_d = PH_READY;
      default:      phase_d = PH_WAIT;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_WAIT:    limit = WAIT_LAST;
      PH_REFRESH: limit = REF_LAST;
      PH_GAP:     limit = GAP_LAST;
      default:    limit = '0;
    endcase
  end

  assign run   = (phase_q == PH_WAIT) || (phase_q == PH_REFRESH) || (phase_q == PH_GAP);
  assign clear = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_WAIT;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/sdinit_cmd_enc.sv
module sdinit_cmd_enc
  import sdinit_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BA_W      = 2,
  parameter int                PALL_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h021
) (
  input  phase_e            phase,
  output sdcmd_t            cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (phase)
      PH_WAIT:      cmd = CMD_NOP;
      PH_PRECHARGE: begin cmd = CMD_PALL;  addr = PALL_ADDR; end
      PH_REFRESH:   cmd = CMD_AREF;
      PH_MODESET:   begin cmd = CMD_LMODE; addr = MODE_WORD; end
      PH_GAP:       cmd = CMD_DESEL;
      PH_READY:     cmd = CMD_NOP;
      default:      cmd = CMD_NOP;
    endcase
  end

  assign ba   = '0;
  assign done = (phase == PH_READY);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int                ADDR_W          = 13,
  parameter int                BA_W            = 2,
  parameter int                WAIT_CYCLES     = 10000,
  parameter int                REFRESH_COUNT   = 8,
  parameter int                RECOVERY_CYCLES = 2,
  parameter int                PALL_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD       = 13'h021
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int unsigned LONGEST = max3(WAIT_CYCLES, REFRESH_COUNT, RECOVERY_CYCLES);
  localparam int          CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);

  phase_e           phase;
  logic             t_run, t_clear, t_hit;
  logic [CNT_W-1:0] t_limit;
  sdcmd_t           cmd;

  sdinit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (t_run),
    .clear (t_clear),
    .limit (t_limit),
    .hit   (t_hit)
  );

  sdinit_fsm #(
    .WAIT_CYCLES     (WAIT_CYCLES),
    .REFRESH_COUNT   (REFRESH_COUNT),
    .RECOVERY_CYCLES (RECOVERY_CYCLES),
    .CNT_W           (CNT_W)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (t_hit),
    .phase (phase),
    .run   (t_run),
    .clear (t_clear),
    .limit (t_limit)
  );

  sdinit_cmd_enc #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .PALL_BIT  (PALL_BIT),
    .MODE_WORD (MODE_WORD)
  ) u_enc (
    .phase (phase),
    .cmd   (cmd),
    .ba    (sd_ba),
    .addr  (sd_addr),
    .done  (init_done)
  );

  assign sd_cke   = 1'b1;
  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int                ADDR_W        = 13,
  parameter int                BA_W          = 2,
  parameter int                REFRESH_COUNT = 8,
  parameter int                PALL_BIT      = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD     = 13'h021
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);

  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  logic [7:0] ref_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ref_run <= '0;
    else if (c == 4'b0010) ref_run <= '0;
    else if (c == 4'b0001) ref_run <= ref_run + 1'b1;
  end

  p_pall_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> (sd_addr[PALL_BIT] && sd_ba == '0));

  p_pall_then_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |=> (c == 4'b0001));

  p_ref_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (ref_run == 8'(REFRESH_COUNT)));

  p_mode_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (sd_addr == MODE_WORD));

  p_mode_then_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |=> (c == 4'b1111));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (c == 4'b0111));

  p_cke_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W        (ADDR_W),
  .BA_W          (BA_W),
  .REFRESH_COUNT (REFRESH_COUNT),
  .PALL_BIT      (PALL_BIT),
  .MODE_WORD     (MODE_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W_A = 20;
  localparam int W_B = 1;
  localparam int TOTAL = 110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0]  a_ba;
  logic [12:0] a_addr;
  logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  b_ba;
  logic [12:0] b_addr;

  sdram_init_seq #(.WAIT_CYCLES(W_A)) u_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr), .init_done(a_done));

  sdram_init_seq #(.WAIT_CYCLES(W_B)) u_sdram_init_seq_b (
    .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr), .init_done(b_done));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare one instance against the cycle number k (W = its wait length).
  task automatic check_dut(string id, int w, int k, bit in_reset,
                           logic cke, logic cs, logic ras, logic cas, logic we,
                           logic [1:0] ba, logic [12:0] addr, logic done);
    logic [3:0]  ecmd;
    logic [12:0] eaddr;
    string       tag;
    eaddr = 13'h0;
    if (k < w)             begin ecmd = 4'b0111; tag = "R1"; end
    else if (k == w)       begin ecmd = 4'b0010; eaddr = 13'h400; tag = "R2"; end
    else if (k <= w + 8)   begin ecmd = 4'b0001; tag = "R3"; end
    else if (k == w + 9)   begin ecmd = 4'b0000; eaddr = 13'h021; tag = "R4"; end
    else if (k <= w + 11)  begin ecmd = 4'b1111; tag = "R5"; end
    else                   begin ecmd = 4'b0111; tag = "R6"; end
    if (in_reset) tag = "R8";
    chk(tag, {id, " cmd"},  16'({cs, ras, cas, we}), 16'(ecmd));
    chk(tag, {id, " addr"}, 16'(addr), 16'(eaddr));
    chk(tag, {id, " bank"}, 16'(ba), 16'h0);
    chk(in_reset ? "R8" : "R6", {id, " done"}, 16'(done), 16'(k >= w + 12));
    chk("R7", {id, " cke"}, 16'(cke), 16'h1);
  endtask

  initial begin
    int ka = 0;
    int kb = 0;
    for (int cyc = 0; cyc < TOTAL; cyc++) begin
      @(negedge clk);
      // reset at start, mid-refresh of instance A (R8), and after done (R8)
      rst_n = !((cyc < 3) || (cyc >= 27 && cyc < 29) || (cyc >= 70 && cyc < 72));
      if (!rst_n) begin ka = 0; kb = 0; end
      #1;
      check_dut("A", W_A, ka, !rst_n, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done);
      check_dut("B", W_B, kb, !rst_n, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done);
      if (rst_n) begin ka++; kb++; end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule